// File: doc/BRIEF.md
# Single-Input Operator Token Pipeline

This block runs tokens bound for one-operand dataflow operators through three segments: Load, Fetch and Operate. Such operators have a single input, so no partner operand is ever searched for. Tokens arrive from a waiting-token queue. The Load segment raises an intake request only while it is empty.

A two-entry FIFO joins each pair of neighbouring segments. The Fetch segment uses the token's destination field to read an operator word from a small internal instruction store. The Operate segment applies one of a few unary operations to the operand. It then issues one or more result tokens.

Each result goes to the first available target, in this order: the local processor when it is free, then another processor when one is free, and otherwise back to the token queue through a put request. That last request holds until the queue accepts it. A synchronous initialise input empties every segment and both FIFOs. Segments work independently, so a load, a fetch and an operate step can all happen on the same clock edge.

Top module: `singleOpPipe`

## Requirements
- R1: After reset, and on the clock edge after `init` is sampled high, all three segments are idle and both FIFOs are empty. `getTok` is then 1 and `localValid`, `remoteValid` and `putTok` are all 0.
- R2: `getTok` equals 1 exactly when the Load segment is empty. A token with `qValid`=1 in such a cycle is captured on that edge, and `getTok` is 0 in the next cycle.
- R3: A loaded token moves into the Load-to-Fetch FIFO on an edge where that FIFO was not full at the start of the cycle. That move frees Load, so `getTok` returns to 1 in the next cycle.
- R4: Each inter-segment FIFO holds two entries. When downstream segments stall, the FIFOs fill and Load stays occupied, so `getTok` stays 0.
- R5: Fetch pops the Load-to-Fetch head on an edge where the Fetch-to-Operate FIFO is not full. It pushes the token's data together with the instruction word stored at the token's address.
- R6: Operate takes the Fetch-to-Operate head only while it holds no result. The opcode in instruction bits [ADDR_W+3:ADDR_W+2] selects the result: 0 or 3 passes the operand through, 1 gives the two's-complement negation, and 2 adds one, modulo 2^DATA_W.
- R7: Instruction bits [ADDR_W+1:ADDR_W] hold the copy count minus one, so 1 to 4 identical result tokens are issued, each in a cycle where it is taken. Bits [ADDR_W-1:0] give the result's `outAddr`.
- R8: While a result is pending and `localFree` is 1, `localValid` is 1 and the other two route outputs are 0. The token counts as taken in that cycle.
- R9: While a result is pending, `localFree` is 0 and `remoteFree` is 1, only `remoteValid` is 1, and the token counts as taken.
- R10: While a result is pending and both free flags are 0, only `putTok` is 1. The token counts as taken only when `queueReady` is 1; until then `outData` and `outAddr` hold steady.
- R11: A write with `imemWe`=1 stores `imemData` at `imemAddr` on the clock edge. A fetch in that same cycle reads the old word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init | input | 1 | Synchronous pipeline initialise |
| qValid | input | 1 | Queue offers a token |
| qData | input | DATA_W | Offered token operand |
| qAddr | input | ADDR_W | Offered token destination address |
| getTok | output | 1 | Intake request (Load empty) |
| imemWe | input | 1 | Instruction store write enable |
| imemAddr | input | ADDR_W | Instruction store write address |
| imemData | input | ADDR_W+4 | Instruction word to write |
| localFree | input | 1 | Local processor can take a result |
| remoteFree | input | 1 | Some other processor can take a result |
| queueReady | input | 1 | Token queue accepts a put |
| localValid | output | 1 | Result offered to the local processor |
| remoteValid | output | 1 | Result offered to a remote processor |
| putTok | output | 1 | Result written back to the token queue |
| outData | output | DATA_W | Result operand |
| outAddr | output | ADDR_W | Result destination address |

## Verification
The bench goes after back-pressure. It holds the queue closed until both FIFOs and the Load segment are full. A design that checked FIFO space wrongly would overwrite or drop tokens, or keep raising `getTok` while it had no room.

The bench flips `localFree` and `remoteFree` while a multi-copy result is pending. A wrong priority order would show up as the wrong route output, and a faulty copy counter as too many or too few result tokens.

The stimulus includes operands 0 and all-ones, and all four opcodes. A wrong negation or a wrap error in the increment then gives a mismatching `outData`. An `init` pulse in the middle of a stream checks that no stale token survives the initialise.

// File: rtl/sopPkg.sv
package sopPkg;
  // strobes from the control to the datapath, one per segment action
  typedef struct packed {
    logic loadTake;   // queue -> Load register
    logic loadMove;   // Load register -> Load/Fetch FIFO
    logic fetchGo;    // Load/Fetch head + instruction -> Fetch/Operate FIFO
    logic opTake;     // Fetch/Operate head -> result register
  } strobe_t;

  typedef enum logic [1:0] {
    OP_PASS = 2'd0,
    OP_NEG  = 2'd1,
    OP_INC  = 2'd2,
    OP_KEEP = 2'd3
  } unop_e;
endpackage

// File: rtl/tokFifo.sv
module tokFifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] headData,
  output logic             full,
  output logic             empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] store [DEPTH];
  logic [PTR_W-1:0] rdPtr, wrPtr;
  logic [CNT_W-1:0] count;
  logic doPush, doPop;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full     = (count == CNT_W'(DEPTH));
  assign empty    = (count == '0);
  assign doPush   = push && !full;
  assign doPop    = pop && !empty;
  assign headData = store[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) store[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else if (clr) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      if (doPush && !doPop)      count <= count + 1'b1;
      else if (doPop && !doPush) count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/sopCtrl.sv
module sopCtrl
  import sopPkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       init,
  input  logic       qValid,
  input  logic       lfFull,
  input  logic       lfEmpty,
  input  logic       foFull,
  input  logic       foEmpty,
  input  logic [1:0] foLit,
  input  logic       localFree,
  input  logic       remoteFree,
  input  logic       queueReady,
  output strobe_t    stb,
  output logic       getTok,
  output logic       localValid,
  output logic       remoteValid,
  output logic       putTok
);
  logic       loadBusy;
  logic       opBusy;
  logic [1:0] copyLeft;
  logic       fire;

  // segment decisions, evaluated independently so they can share a cycle
  always_comb begin
    stb.loadTake = !loadBusy && qValid;
    stb.loadMove = loadBusy && !lfFull;
    stb.fetchGo  = !lfEmpty && !foFull;
    stb.opTake   = !opBusy && !foEmpty;
  end

  assign getTok      = !loadBusy;
  assign localValid  = opBusy && localFree;
  assign remoteValid = opBusy && !localFree && remoteFree;
  assign putTok      = opBusy && !localFree && !remoteFree;
  assign fire        = localValid || remoteValid || (putTok && queueReady);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loadBusy <= 1'b0;
      opBusy   <= 1'b0;
      copyLeft <= '0;
    end else if (init) begin
      loadBusy <= 1'b0;
      opBusy   <= 1'b0;
      copyLeft <= '0;
    end else begin
      if (stb.loadTake)      loadBusy <= 1'b1;
      else if (stb.loadMove) loadBusy <= 1'b0;

      if (stb.opTake) begin
        opBusy   <= 1'b1;
        copyLeft <= foLit;
      end else if (fire) begin
        if (copyLeft == '0) opBusy <= 1'b0;
        else                copyLeft <= copyLeft - 2'd1;
      end
    end
  end
endmodule

// File: rtl/sopData.sv
module sopData
  import sopPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4,
  parameter int FIFO_D = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                init,
  input  strobe_t             stb,
  input  logic [DATA_W-1:0]   qData,
  input  logic [ADDR_W-1:0]   qAddr,
  input  logic                imemWe,
  input  logic [ADDR_W-1:0]   imemAddr,
  input  logic [ADDR_W+3:0]   imemData,
  output logic                lfFull,
  output logic                lfEmpty,
  output logic                foFull,
  output logic                foEmpty,
  output logic [1:0]          foLit,
  output logic [DATA_W-1:0]   outData,
  output logic [ADDR_W-1:0]   outAddr
);
  localparam int INSTR_W = ADDR_W + 4;
  localparam int TOK_W   = DATA_W + ADDR_W;
  localparam int FO_W    = DATA_W + INSTR_W;
  localparam int IMEM_D  = 1 << ADDR_W;

  logic [TOK_W-1:0]   loadTok;
  logic [TOK_W-1:0]   lfHead;
  logic [FO_W-1:0]    foHead;
  logic [INSTR_W-1:0] imem [IMEM_D];
  logic [INSTR_W-1:0] fetched;
  logic [INSTR_W-1:0] foInstr;
  logic [DATA_W-1:0]  foData;
  logic [DATA_W-1:0]  opResult;
  unop_e              opSel;

  always_ff @(posedge clk) begin
    if (imemWe) imem[imemAddr] <= imemData;
  end

  always_ff @(posedge clk) begin
    if (stb.loadTake) loadTok <= {qData, qAddr};
  end

  tokFifo #(.WIDTH(TOK_W), .DEPTH(FIFO_D)) u_lf (
    .clk(clk), .rst_n(rst_n), .clr(init),
    .push(stb.loadMove), .pushData(loadTok),
    .pop(stb.fetchGo), .headData(lfHead),
    .full(lfFull), .empty(lfEmpty)
  );

  // Fetch: instruction looked up by the head token's destination address
  assign fetched = imem[lfHead[ADDR_W-1:0]];

  tokFifo #(.WIDTH(FO_W), .DEPTH(FIFO_D)) u_fo (
    .clk(clk), .rst_n(rst_n), .clr(init),
    .push(stb.fetchGo), .pushData({lfHead[TOK_W-1:ADDR_W], fetched}),
    .pop(stb.opTake), .headData(foHead),
    .full(foFull), .empty(foEmpty)
  );

  assign foInstr = foHead[INSTR_W-1:0];
  assign foData  = foHead[FO_W-1:INSTR_W];
  assign foLit   = foInstr[ADDR_W+1:ADDR_W];
  assign opSel   = unop_e'(foInstr[ADDR_W+3:ADDR_W+2]);

  always_comb begin
    unique case (opSel)
      OP_NEG:  opResult = -foData;
      OP_INC:  opResult = foData + 1'b1;
      default: opResult = foData;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outData <= '0;
      outAddr <= '0;
    end else if (stb.opTake) begin
      outData <= opResult;
      outAddr <= foInstr[ADDR_W-1:0];
    end
  end
endmodule

// File: rtl/singleOpPipe.sv
module singleOpPipe
  import sopPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4,
  parameter int FIFO_D = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  logic              qValid,
  input  logic [DATA_W-1:0] qData,
  input  logic [ADDR_W-1:0] qAddr,
  output logic              getTok,
  input  logic              imemWe,
  input  logic [ADDR_W-1:0] imemAddr,
  input  logic [ADDR_W+3:0] imemData,
  input  logic              localFree,
  input  logic              remoteFree,
  input  logic              queueReady,
  output logic              localValid,
  output logic              remoteValid,
  output logic              putTok,
  output logic [DATA_W-1:0] outData,
  output logic [ADDR_W-1:0] outAddr
);
  strobe_t    stb;
  logic       lfFull, lfEmpty, foFull, foEmpty;
  logic [1:0] foLit;

  sopCtrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .init(init), .qValid(qValid),
    .lfFull(lfFull), .lfEmpty(lfEmpty), .foFull(foFull), .foEmpty(foEmpty),
    .foLit(foLit), .localFree(localFree), .remoteFree(remoteFree),
    .queueReady(queueReady), .stb(stb), .getTok(getTok),
    .localValid(localValid), .remoteValid(remoteValid), .putTok(putTok)
  );

  sopData #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .FIFO_D(FIFO_D)) u_data (
    .clk(clk), .rst_n(rst_n), .init(init), .stb(stb),
    .qData(qData), .qAddr(qAddr),
    .imemWe(imemWe), .imemAddr(imemAddr), .imemData(imemData),
    .lfFull(lfFull), .lfEmpty(lfEmpty), .foFull(foFull), .foEmpty(foEmpty),
    .foLit(foLit), .outData(outData), .outAddr(outAddr)
  );
endmodule

// File: rtl/sopPipeChk.sv
module sopPipeChk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              init,
  input logic              qValid,
  input logic              getTok,
  input logic              localFree,
  input logic              queueReady,
  input logic              localValid,
  input logic              remoteValid,
  input logic              putTok,
  input logic [DATA_W-1:0] outData,
  input logic [ADDR_W-1:0] outAddr
);
  // R1
  init_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> (getTok && !localValid && !remoteValid && !putTok));

  // R2
  take_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (getTok && qValid && !init) |=> !getTok);

  // R2
  drop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(getTok) |-> $past(qValid));

  // R8
  local_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    localFree |-> (!remoteValid && !putTok));

  // R10
  put_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (putTok && !queueReady && !init) |=>
      ($stable(outData) && $stable(outAddr) && (localValid || remoteValid || putTok)));
endmodule

bind singleOpPipe sopPipeChk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/singleOpPipe_bench.sv
module singleOpPipe_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       init = 1'b0;
  logic       qValid = 1'b0;
  logic [7:0] qData = '0;
  logic [3:0] qAddr = '0;
  logic       getTok;
  logic       imemWe = 1'b0;
  logic [3:0] imemAddr = '0;
  logic [7:0] imemData = '0;
  logic       localFree = 1'b0;
  logic       remoteFree = 1'b0;
  logic       queueReady = 1'b0;
  logic       localValid, remoteValid, putTok;
  logic [7:0] outData;
  logic [3:0] outAddr;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  singleOpPipe u_singleOpPipe (
    .clk(clk), .rst_n(rst_n), .init(init), .qValid(qValid), .qData(qData),
    .qAddr(qAddr), .getTok(getTok), .imemWe(imemWe), .imemAddr(imemAddr),
    .imemData(imemData), .localFree(localFree), .remoteFree(remoteFree),
    .queueReady(queueReady), .localValid(localValid), .remoteValid(remoteValid),
    .putTok(putTok), .outData(outData), .outAddr(outAddr)
  );

  always #4 clk = ~clk;

  // ---------------- behavioural reference model ----------------
  logic [7:0] mImem [16];
  bit         mLoadBusy = 0;
  logic [7:0] mLoadD;
  logic [3:0] mLoadA;
  logic [7:0] lfD[$];
  logic [3:0] lfA[$];
  logic [7:0] foD[$];
  logic [7:0] foI[$];
  bit         mOpBusy = 0;
  logic [7:0] mResD = '0;
  logic [3:0] mResA = '0;
  int         mLeft = 0;
  bit         take, move, fgo, otake, fire;
  logic [7:0] fInstr, fData, oD, oI;

  function automatic logic [7:0] unop(input logic [1:0] op, input logic [7:0] d);
    if (op == 2'd1) return 8'(0 - d);       // R6 negate
    if (op == 2'd2) return 8'(d + 1);       // R6 increment
    return d;                               // R6 pass
  endfunction

  always @(posedge clk) begin
    if (!rst_n || init) begin
      mLoadBusy = 0; mOpBusy = 0; mLeft = 0;
      lfD.delete(); lfA.delete(); foD.delete(); foI.delete();
    end else begin
      take  = !mLoadBusy && qValid;
      move  = mLoadBusy && (lfA.size() < 2);
      fgo   = (lfA.size() > 0) && (foI.size() < 2);
      otake = !mOpBusy && (foI.size() > 0);
      fire  = mOpBusy && (localFree || remoteFree || queueReady);
      if (fgo) begin fInstr = mImem[lfA[0]]; fData = lfD[0]; end
      if (otake) begin
        oD = foD.pop_front(); oI = foI.pop_front();
        mResD = unop(oI[7:6], oD); mResA = oI[3:0]; mLeft = int'(oI[5:4]); mOpBusy = 1;
      end else if (fire) begin
        if (mLeft == 0) mOpBusy = 0; else mLeft = mLeft - 1;
      end
      if (fgo) begin
        void'(lfD.pop_front()); void'(lfA.pop_front());
        foD.push_back(fData); foI.push_back(fInstr);
      end
      if (move) begin lfD.push_back(mLoadD); lfA.push_back(mLoadA); mLoadBusy = 0; end
      if (take) begin mLoadBusy = 1; mLoadD = qData; mLoadA = qAddr; end
    end
    if (imemWe) mImem[imemAddr] = imemData;  // R11 written at the edge
  end

  // ---------------- checking ----------------
  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    chk("R2 R3 R4 getTok", 32'(getTok), 32'(!mLoadBusy));
    chk("R8 localValid", 32'(localValid), 32'(mOpBusy && localFree));
    chk("R9 remoteValid", 32'(remoteValid), 32'(mOpBusy && !localFree && remoteFree));
    chk("R10 putTok", 32'(putTok), 32'(mOpBusy && !localFree && !remoteFree));
    if (mOpBusy) begin
      chk("R5 R6 R11 outData", 32'(outData), 32'(mResD));
      chk("R7 outAddr", 32'(outAddr), 32'(mResA));
    end
  endtask

  task automatic step(input bit qv, input logic [7:0] qd, input logic [3:0] qa,
                      input bit lf, input bit rf, input bit qr, input bit in);
    @(negedge clk);
    qValid = qv; qData = qd; qAddr = qa;
    localFree = lf; remoteFree = rf; queueReady = qr; init = in;
    #1 compareAll();
  endtask

  function automatic logic [7:0] pickData();
    int r = $urandom_range(0, 5);
    if (r == 0) return 8'h00;
    if (r == 1) return 8'hFF;
    return 8'($urandom_range(0, 255));
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 reset getTok", 32'(getTok), 32'd1);
    chk("R1 reset routes", 32'({localValid, remoteValid, putTok}), 32'd0);

    // R11 program the instruction store: opcode i%4, copies-1 (i/4)%4, dest 15-i
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      imemWe = 1'b1; imemAddr = 4'(i);
      imemData = {2'(i % 4), 2'((i / 4) % 4), 4'(15 - i)};
    end
    @(negedge clk); imemWe = 1'b0;

    // R8 local route, all opcodes and copy counts, concurrency of segments
    for (int c = 0; c < 60; c++)
      step($urandom_range(0, 3) != 0, pickData(), 4'($urandom_range(0, 15)), 1, 0, 0, 0);
    // R9 remote route
    for (int c = 0; c < 60; c++)
      step($urandom_range(0, 1) == 1, pickData(), 4'($urandom_range(0, 15)), 0, 1, 0, 0);
    // R10 queue write-back with a stalling queue
    for (int c = 0; c < 80; c++)
      step($urandom_range(0, 1) == 1, pickData(), 4'($urandom_range(0, 15)), 0, 0,
           $urandom_range(0, 1) == 1, 0);
    // R4 full back-pressure
    for (int c = 0; c < 40; c++)
      step(1, pickData(), 4'($urandom_range(0, 15)), 0, 0, 0, 0);
    chk("R4 intake blocked when full", 32'(getTok), 32'd0);
    chk("R10 put held", 32'(putTok), 32'd1);

    // R1 initialise in mid-stream
    step(1, 8'h11, 4'd3, 0, 0, 0, 1);
    step(0, 8'h00, 4'd0, 0, 0, 0, 0);
    chk("R1 init getTok", 32'(getTok), 32'd1);
    chk("R1 init routes", 32'({localValid, remoteValid, putTok}), 32'd0);

    // mixed traffic: flipping free flags during multi-copy results (R7 R8 R9 R10)
    for (int c = 0; c < 300; c++)
      step($urandom_range(0, 2) != 0, pickData(), 4'($urandom_range(0, 15)),
           $urandom_range(0, 2) == 0, $urandom_range(0, 1) == 1,
           $urandom_range(0, 1) == 1, 0);
    // drain
    for (int c = 0; c < 40; c++)
      step(0, 8'h00, 4'd0, 1, 0, 0, 0);
    chk("R3 R5 drained pipeline idle", 32'({getTok, localValid}), 32'b10);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule